// File: doc/BRIEF.md
# Register-Mapped EDID Read Controller

This block lets a host fetch monitor identification bytes through four 32-bit registers on a simple synchronous register bus. The registers are a pin/port selector, a command word, a status word and a data word. The host first picks a pin. It then writes a command that names the target slave address, an optional start index, a total byte count and a cycle type. After that it reads the data register repeatedly. Each data read pops up to four bytes from an internal 128-byte identification table. The bytes are packed with the lowest-addressed byte in the least significant lane.

Status bits and the bus phase change only as side effects of register accesses. A selector write checks the per-port monitor-present input and reports a missing monitor through an acknowledge-error flag. A completed transfer leaves the phase at idle if the command carried a STOP. Otherwise the phase is left at wait. In both cases the read state is cleared, so the next transaction starts with a new selector write. Reads return data one cycle after the request. If a read and a write are requested in the same cycle, the write is performed and the read is dropped.

Top module: `edid_regctl`

## Requirements
- R1: After reset, the status register reads 0x1 (only READY set), the phase output is 0 (idle), and the data register reads 0.
- R2: Register addresses are 0 = selector, 1 = command, 2 = status, 3 = data. The selector and command registers read back the last value written, except that command bit 30 (software-ready) always reads 0. Read data appears on `bus_rdata` in the cycle after the read request.
- R3: A selector write always clears the read state (pointer, byte count, slave match, availability, stored cycle) and sets the phase to idle. Pin = bits 2:0. Pins 1..NPORTS select port pin-1, set READY (status bit 0) and clear ACTIVE (status bit 1). Pin 0 and pins above NPORTS leave the status word unchanged.
- R4: On a selector write to a valid pin, ACK_ERR (status bit 2) is set if that port's monitor-present input is 0. If the input is 1, ACK_ERR is cleared and the table is marked available.
- R5: Command fields are: bit 0 = read direction, bits 7:1 = slave address, bits 15:8 = start index, bits 24:16 = total byte count, bits 27:25 = cycle. Only slave address 0x50 selects the table. Any other address leaves the slave unselected.
- R6: Cycle bit 26 (index) loads the start index into the read pointer. Cycle values with bit 25 set (1, 3, 5, 7) move the phase to data (1) and set ACTIVE.
- R7: Cycle value 4 (STOP only) takes effect only if the previously stored command cycle field is nonzero. When it takes effect, it clears the read state, sets the phase to idle and clears ACTIVE. Otherwise the phase and ACTIVE are unchanged.
- R8: A data read with command bit 0 set and bytes remaining (total minus pointer greater than 0) returns min(4, remaining) bytes. The first byte is in bits 7:0. Unused upper lanes read as 0.
- R9: A data read that returns the last remaining bytes sets the phase to idle (0) if cycle bit 27 (STOP) was set, and to wait (2) otherwise. It also clears the read state.
- R10: A data read with no bytes remaining, or with command bit 0 clear, returns the previously returned data word. Writes to the data register have no effect.
- R11: A fetched byte is 0, and the pointer does not advance for it, if the pointer is at 128 or above, no slave is selected, or the table is unavailable.
- R12: A status read returns the status value as it was before the read, then sets IN_USE (status bit 3). Writing a 1 to bit 3 of the status register clears IN_USE. All other status bits ignore writes.
- R13: Table byte k is 0x00 for k = 0 and k = 7, 0xFF for k = 1..6, and (37*k + 11) mod 256 for all other k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| mon_present | input | NPORTS | Monitor attached, one bit per port |
| phase_dbg | output | 2 | Bus phase: 0 idle, 1 data, 2 wait |

## Verification
A corrupted read pointer or byte count shows up on the very next data read, either as bytes from the wrong table offset or as a transfer that ends too early or too late. The phase output exposes that error one read earlier. A wrong availability or slave-match flag turns expected table bytes into zeros on the first data read. A stale stored cycle field shows up only when a later STOP-only command is applied or not applied, so the stimulus writes a STOP after both a zero and a nonzero stored cycle. The status register is read directly after every action that should change it, which also exercises the IN_USE side effect.

// File: rtl/edid_regctl_pkg.sv
package edid_regctl_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DATA = 2'd1,
      PH_WAIT = 2'd2
   } phase_e;

   localparam logic [1:0] RA_SEL  = 2'd0;
   localparam logic [1:0] RA_CMD  = 2'd1;
   localparam logic [1:0] RA_STAT = 2'd2;
   localparam logic [1:0] RA_DATA = 2'd3;

   // status bit positions
   localparam int ST_READY  = 0;
   localparam int ST_ACTIVE = 1;
   localparam int ST_NAK    = 2;
   localparam int ST_INUSE  = 3;

   // command field positions
   localparam int CMD_RD    = 0;
   localparam int CMD_ADR_L = 1;
   localparam int CMD_IDX_L = 8;
   localparam int CMD_CNT_L = 16;
   localparam int CMD_CNT_W = 9;
   localparam int CMD_CYC_L = 25;
   localparam int CMD_SWRDY = 30;

   // bits inside the 3-bit cycle field
   localparam int CYC_DATA = 0;
   localparam int CYC_IDX  = 1;
   localparam int CYC_STOP = 2;
   localparam logic [2:0] CYC_STOP_ONLY = 3'b100;

endpackage

// File: rtl/edid_rom.sv
module edid_rom #(
   parameter int DEPTH = 128,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic [AW-1:0] idx,
   output logic [7:0]    dout
);
   always_comb begin
      if (idx == AW'(0) || idx == AW'(7))
         dout = 8'h00;
      else if (idx <= AW'(6))
         dout = 8'hFF;
      else
         dout = 8'((32'(idx) * 32'd37) + 32'd11);
   end
endmodule

// File: rtl/edid_pack.sv
module edid_pack #(
   parameter int LANES = 4,
   parameter int CNT_W = 9,
   parameter int DEPTH = 128
) (
   input  logic [CNT_W-1:0]             ptr,
   input  logic [CNT_W-1:0]             total,
   input  logic                         fetch_ok,
   output logic [LANES*8-1:0]           word,
   output logic [$clog2(LANES+1)-1:0]   n_valid,
   output logic                         any_left,
   output logic                         last
);
   localparam int AW = $clog2(DEPTH);
   localparam int LW = $clog2(LANES+1);

   logic signed [CNT_W+1:0] left;
   logic [LANES-1:0]        lane_ok;

   assign left = $signed({2'b00, total}) - $signed({2'b00, ptr});

   for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      logic [CNT_W:0] a;
      logic [7:0]     rb;
      assign a = {1'b0, ptr} + (CNT_W+1)'(gl);
      edid_rom #(.DEPTH(DEPTH)) u_rom (.idx(a[AW-1:0]), .dout(rb));
      assign lane_ok[gl] = fetch_ok
                         && (left > $signed((CNT_W+2)'(gl)))
                         && (a < (CNT_W+1)'(DEPTH));
      assign word[gl*8 +: 8] = lane_ok[gl] ? rb : 8'h00;
   end

   always_comb begin
      n_valid = '0;
      for (int i = 0; i < LANES; i++)
         n_valid = n_valid + LW'(lane_ok[i]);
   end

   assign any_left = (left > $signed((CNT_W+2)'(0)));
   assign last     = any_left && (left <= $signed((CNT_W+2)'(LANES)));
endmodule

// File: rtl/edid_regctl.sv
module edid_regctl
   import edid_regctl_pkg::*;
#(
   parameter int         NPORTS   = 4,
   parameter int         LANES    = 4,
   parameter int         DEPTH    = 128,
   parameter logic [6:0] SLAVE_ID = 7'h50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   input  logic [NPORTS-1:0] mon_present,
   output logic [1:0]        phase_dbg
);
   localparam int CNT_W = CMD_CNT_W;
   localparam int LW    = $clog2(LANES+1);

   if (NPORTS < 1 || NPORTS > 7) begin : g_bad_ports
      $error("NPORTS must be 1..7");
   end
   if (LANES < 1 || LANES > 4) begin : g_bad_lanes
      $error("LANES must be 1..4");
   end
   if (DEPTH < 8 || DEPTH > 256 || (DEPTH & (DEPTH-1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two in 8..256");
   end

   logic [31:0]      sel_q, cmd_q, data_q, rdata_q;
   logic             st_ready, st_active, st_nak, st_inuse;
   phase_e           phase_q;
   logic [CNT_W-1:0] ptr_q, total_q;
   logic [2:0]       cyc_q;
   logic             slave_q, avail_q;

   logic [LANES*8-1:0] pk_word;
   logic [LW-1:0]      pk_nvalid;
   logic               pk_any, pk_last;

   edid_pack #(.LANES(LANES), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_pack (
      .ptr(ptr_q), .total(total_q), .fetch_ok(slave_q && avail_q),
      .word(pk_word), .n_valid(pk_nvalid), .any_left(pk_any), .last(pk_last)
   );

   // pin decode
   logic [2:0] wpin;
   logic       pin_ok, pin_mon;
   assign wpin = bus_wdata[2:0];
   always_comb begin
      pin_ok  = 1'b0;
      pin_mon = 1'b0;
      for (int i = 0; i < NPORTS; i++) begin
         if (wpin == 3'(i + 1)) begin
            pin_ok  = 1'b1;
            pin_mon = mon_present[i];
         end
      end
   end

   // command decode
   logic [2:0] w_cyc;
   logic       pop_ok, rd_go;
   assign w_cyc  = bus_wdata[CMD_CYC_L +: 3];
   assign pop_ok = cmd_q[CMD_RD] && pk_any;
   assign rd_go  = bus_rd && !bus_wr;

   logic [31:0] st_word, rd_mux;
   assign st_word = {28'd0, st_inuse, st_nak, st_active, st_ready};
   always_comb begin
      unique case (bus_addr)
         RA_SEL:  rd_mux = sel_q;
         RA_CMD:  rd_mux = cmd_q;
         RA_STAT: rd_mux = st_word;
         default: rd_mux = pop_ok ? 32'(pk_word) : data_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;  cmd_q <= '0;  data_q <= '0;  rdata_q <= '0;
         st_ready <= 1'b1;  st_active <= 1'b0;
         st_nak <= 1'b0;    st_inuse <= 1'b0;
         phase_q <= PH_IDLE;
         ptr_q <= '0;  total_q <= '0;  cyc_q <= '0;
         slave_q <= 1'b0;  avail_q <= 1'b0;
      end else if (bus_wr) begin
         unique case (bus_addr)
            RA_SEL: begin
               sel_q <= bus_wdata;
               ptr_q <= '0;  total_q <= '0;  cyc_q <= '0;
               slave_q <= 1'b0;  avail_q <= 1'b0;
               phase_q <= PH_IDLE;
               if (pin_ok) begin
                  st_ready  <= 1'b1;
                  st_active <= 1'b0;
                  st_nak    <= !pin_mon;
                  avail_q   <= pin_mon;
               end
            end
            RA_CMD: begin
               total_q <= bus_wdata[CMD_CNT_L +: CNT_W];
               cyc_q   <= w_cyc;
               if (bus_wdata[CMD_ADR_L +: 7] == SLAVE_ID)
                  slave_q <= 1'b1;
               if (w_cyc[CYC_IDX])
                  ptr_q <= CNT_W'(bus_wdata[CMD_IDX_L +: 8]);
               if (w_cyc[CYC_DATA]) begin
                  phase_q   <= PH_DATA;
                  st_active <= 1'b1;
               end else if (w_cyc == CYC_STOP_ONLY
                            && cmd_q[CMD_CYC_L +: 3] != 3'd0) begin
                  ptr_q <= '0;  total_q <= '0;  cyc_q <= '0;
                  slave_q <= 1'b0;  avail_q <= 1'b0;
                  phase_q   <= PH_IDLE;
                  st_active <= 1'b0;
               end
               cmd_q <= bus_wdata & ~(32'd1 << CMD_SWRDY);
            end
            RA_STAT: begin
               if (bus_wdata[ST_INUSE]) st_inuse <= 1'b0;
            end
            default: ;
         endcase
      end else if (rd_go) begin
         rdata_q <= rd_mux;
         if (bus_addr == RA_STAT) st_inuse <= 1'b1;
         if (bus_addr == RA_DATA && pop_ok) begin
            data_q <= rd_mux;
            ptr_q  <= ptr_q + CNT_W'(pk_nvalid);
            if (pk_last) begin
               phase_q <= cyc_q[CYC_STOP] ? PH_IDLE : PH_WAIT;
               ptr_q <= '0;  total_q <= '0;  cyc_q <= '0;
               slave_q <= 1'b0;  avail_q <= 1'b0;
            end
         end
      end
   end

   assign bus_rdata = rdata_q;
   assign phase_dbg = phase_q;
endmodule

// File: rtl/edid_regctl_chk.sv
module edid_regctl_chk
   import edid_regctl_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic [1:0]  bus_addr,
   input logic        bus_wr,
   input logic        bus_rd,
   input logic [2:0]  w_cyc,
   input logic [31:0] bus_rdata,
   input logic [1:0]  phase_dbg,
   input logic        st_inuse,
   input logic        st_active,
   input logic [31:0] data_q,
   input logic [31:0] cmd_q
);
   // R6
   phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_dbg != 2'd3);

   // R12
   inuse_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == RA_STAT) |=> st_inuse);

   // R3
   sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == RA_SEL) |=> phase_dbg == 2'd0);

   // R10
   data_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == RA_DATA) |=> $stable(data_q));

   // R10
   held_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == RA_DATA && !cmd_q[CMD_RD])
      |=> bus_rdata == $past(data_q));

   // R7
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == RA_CMD && w_cyc == CYC_STOP_ONLY
       && cmd_q[CMD_CYC_L +: 3] != 3'd0)
      |=> (phase_dbg == 2'd0 && !st_active));
endmodule

bind edid_regctl edid_regctl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .w_cyc(w_cyc), .bus_rdata(bus_rdata),
   .phase_dbg(phase_dbg), .st_inuse(st_inuse), .st_active(st_active),
   .data_q(data_q), .cmd_q(cmd_q)
);

// File: tb/tb_edid_regctl.sv
module tb_edid_regctl;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 39;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  mon_present = 4'b0101;
   logic [1:0]  phase_dbg;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   edid_regctl dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .mon_present(mon_present), .phase_dbg(phase_dbg)
   );

   // {req[4], rd[1], addr[2], wdata[32], expected[32], phase[2]}
   localparam logic [72:0] VEC [NV] = '{
      {4'd1,  1'b1, 2'd2, 32'h0, 32'h00000001, 2'd0}, // R1 status after reset
      {4'd12, 1'b1, 2'd2, 32'h0, 32'h00000009, 2'd0}, // R12 in-use now set
      {4'd12, 1'b0, 2'd2, 32'h8, 32'h0,        2'd0}, // R12 clear in-use
      {4'd12, 1'b1, 2'd2, 32'h0, 32'h00000001, 2'd0}, // R12
      {4'd1,  1'b1, 2'd3, 32'h0, 32'h00000000, 2'd0}, // R1 data after reset
      {4'd3,  1'b0, 2'd0, 32'h1, 32'h0,        2'd0}, // R3 pin 1, monitor
      {4'd6,  1'b0, 2'd1, 32'h4A0A00A1, 32'h0, 2'd1}, // R6 cyc5, count 10
      {4'd2,  1'b1, 2'd1, 32'h0, 32'h0A0A00A1, 2'd1}, // R2 sw-ready dropped
      {4'd2,  1'b1, 2'd0, 32'h0, 32'h00000001, 2'd1}, // R2 selector readback
      {4'd8,  1'b1, 2'd3, 32'h0, 32'hFFFFFF00, 2'd1}, // R8 bytes 0..3
      {4'd8,  1'b1, 2'd3, 32'h0, 32'h00FFFFFF, 2'd1}, // R8 bytes 4..7
      {4'd9,  1'b1, 2'd3, 32'h0, 32'h00005833, 2'd0}, // R9 last two, STOP
      {4'd10, 1'b1, 2'd3, 32'h0, 32'h00005833, 2'd0}, // R10 nothing left
      {4'd12, 1'b1, 2'd2, 32'h0, 32'h0000000B, 2'd0}, // R12 active kept
      {4'd12, 1'b0, 2'd2, 32'h8, 32'h0,        2'd0}, // R12
      {4'd10, 1'b0, 2'd3, 32'h12345678, 32'h0, 2'd0}, // R10 data write
      {4'd10, 1'b1, 2'd3, 32'h0, 32'h00005833, 2'd0}, // R10 unchanged
      {4'd3,  1'b0, 2'd0, 32'h1, 32'h0,        2'd0}, // R3
      {4'd5,  1'b0, 2'd1, 32'h060E0CA1, 32'h0, 2'd1}, // R5 index 12, count 14
      {4'd9,  1'b1, 2'd3, 32'h0, 32'h0000ECC7, 2'd2}, // R9 no STOP -> wait
      {4'd7,  1'b0, 2'd1, 32'h08000000, 32'h0, 2'd0}, // R7 stop after cyc3
      {4'd7,  1'b1, 2'd2, 32'h0, 32'h00000001, 2'd0}, // R7 active cleared
      {4'd6,  1'b0, 2'd1, 32'h020000A1, 32'h0, 2'd1}, // R6 cyc1
      {4'd7,  1'b0, 2'd1, 32'h00000000, 32'h0, 2'd1}, // R7 store cycle 0
      {4'd7,  1'b0, 2'd1, 32'h08000000, 32'h0, 2'd1}, // R7 stop ignored
      {4'd7,  1'b1, 2'd2, 32'h0, 32'h0000000B, 2'd1}, // R7 active kept
      {4'd4,  1'b0, 2'd0, 32'h2, 32'h0,        2'd0}, // R4 pin 2, no monitor
      {4'd4,  1'b1, 2'd2, 32'h0, 32'h0000000D, 2'd0}, // R4 ack error set
      {4'd11, 1'b0, 2'd1, 32'h0A0400A1, 32'h0, 2'd1}, // R11 unavailable
      {4'd11, 1'b1, 2'd3, 32'h0, 32'h00000000, 2'd0}, // R11 zero bytes
      {4'd4,  1'b0, 2'd0, 32'h3, 32'h0,        2'd0}, // R4 pin 3, monitor
      {4'd5,  1'b0, 2'd1, 32'h0A0400A3, 32'h0, 2'd1}, // R5 slave 0x51
      {4'd11, 1'b1, 2'd3, 32'h0, 32'h00000000, 2'd0}, // R11 no slave
      {4'd3,  1'b0, 2'd0, 32'h1, 32'h0,        2'd0}, // R3
      {4'd11, 1'b0, 2'd1, 32'h0E827EA1, 32'h0, 2'd1}, // R11 index 126, count 130
      {4'd11, 1'b1, 2'd3, 32'h0, 32'h00006641, 2'd0}, // R11 past end -> 0
      {4'd3,  1'b0, 2'd0, 32'h5, 32'h0,        2'd0}, // R3 pin 5 invalid
      {4'd3,  1'b1, 2'd2, 32'h0, 32'h0000000B, 2'd0}, // R3 status unchanged
      {4'd2,  1'b1, 2'd0, 32'h0, 32'h00000005, 2'd0}  // R2
   };

   function automatic logic [7:0] rom_ref(input int k);
      if (k == 0 || k == 7) return 8'h00;
      if (k < 7) return 8'hFF;
      return 8'((37 * k + 11) % 256);
   endfunction

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d: actual %h expected %h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic bus_op(input logic rd, input logic [1:0] a, input logic [31:0] wd,
                         output logic [31:0] rv, output logic [1:0] ph);
      bus_addr = a; bus_wdata = wd; bus_rd = rd; bus_wr = !rd;
      @(negedge clk);
      rv = bus_rdata; ph = phase_dbg;
      bus_rd = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL R1: watchdog expired, actual hung expected done");
      finish_run();
   end

   initial begin
      logic [31:0] rv;
      logic [1:0]  ph;
      logic [31:0] w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(1, 32'(phase_dbg), 32'd0); // R1 phase after reset

      for (int i = 0; i < NV; i++) begin
         bus_op(VEC[i][68], VEC[i][67:66], VEC[i][65:34], rv, ph);
         if (VEC[i][68]) check(int'(VEC[i][72:69]), rv, VEC[i][33:2]);
         check(int'(VEC[i][72:69]), 32'(ph), 32'(VEC[i][1:0]));
      end

      // R3: pin 0 clears read state but leaves status alone
      bus_op(1'b0, 2'd0, 32'h1, rv, ph);
      bus_op(1'b0, 2'd1, 32'h0A0800A1, rv, ph);
      bus_op(1'b0, 2'd0, 32'h0, rv, ph);
      check(3, 32'(ph), 32'd0);
      bus_op(1'b1, 2'd3, 32'h0, rv, ph);
      check(3, rv, 32'h00006641);
      bus_op(1'b1, 2'd2, 32'h0, rv, ph);
      check(3, rv, 32'h0000000B);

      // R13 / R8: sweep the whole table
      bus_op(1'b0, 2'd0, 32'h1, rv, ph);
      bus_op(1'b0, 2'd1, 32'h0E8000A1, rv, ph);
      for (int k = 0; k < 32; k++) begin
         bus_op(1'b1, 2'd3, 32'h0, rv, ph);
         w = {rom_ref(4*k+3), rom_ref(4*k+2), rom_ref(4*k+1), rom_ref(4*k)};
         check(13, rv, w);
      end
      check(9, 32'(ph), 32'd0); // R9 STOP -> idle after sweep

      // R1: reset in the middle of a transfer
      bus_op(1'b0, 2'd0, 32'h1, rv, ph);
      bus_op(1'b0, 2'd1, 32'h0A1000A1, rv, ph);
      bus_op(1'b1, 2'd3, 32'h0, rv, ph);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check(1, 32'(phase_dbg), 32'd0);
      bus_op(1'b1, 2'd2, 32'h0, rv, ph);
      check(1, rv, 32'h00000001);
      bus_op(1'b1, 2'd3, 32'h0, rv, ph);
      check(1, rv, 32'h00000000);

      finish_run();
   end
endmodule